// File: doc/BRIEF.md
# Six-Input Bit-Stacking Population Counter

This block is a combinational 6:3 parallel counter for the reduction tree of a multiplier. Six bits of equal weight go in. Their population count comes out as a 3-bit binary number. The count is not formed with chained full adders. Each group of three inputs is first sorted into a thermometer-coded stack, so that all of its ones are packed at the low end.

Two consecutive stack outputs are then merged. One of them is reversed before the merge, and a second stacking pass follows, which yields an overflow stack that records the ones beyond the third. Both carry outputs come from these stacks through AND/OR logic only. The single exclusive-OR in the block forms the least significant bit. It combines two per-group even-parity terms, each read directly off a stack.

The block holds no state and has no clock. It is meant to be replicated across the columns of a partial-product reduction tree.

Top module: `bitstack_counter63`

## Requirements
- R1: Each 3-bit stacker returns a thermometer code whose number of ones equals the number of ones among its three inputs. Its low bit is the OR of the inputs, its middle bit is the majority and its top bit is the AND.
- R2: Inputs din[2:0] form the lower group and din[5:3] form the upper group. Swapping the contents of the two groups leaves cnt unchanged.
- R3: The overflow stack, which is formed by merging the lower stack with the reversed upper stack and restacking, is a thermometer code that holds max(0, n-3) ones, where n is the number of ones in din.
- R4: cnt[0] is 1 exactly when n is odd.
- R5: cnt[2] is 1 exactly when n is 4 or more.
- R6: cnt[1] is 1 exactly when n is 2, 3 or 6.
- R7: For every one of the 64 values of din, cnt equals n, with cnt[0] of weight 1, cnt[1] of weight 2 and cnt[2] of weight 4.
- R8: The block is purely combinational. cnt follows a change of din without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 6 | Six equally weighted bits to be counted |
| cnt | output | 3 | Binary population count {weight 4, weight 2, weight 1} |

## Verification
The bound checker evaluates the internal stacks whenever din changes, and it does so for every input value. It confirms that both group stacks and the overflow stack stay thermometer-shaped and hold the right number of ones. It also checks each output bit against the parity and threshold conditions on n. The bench's scenarios are what show that the full 64-entry mapping is right and that the two input groups are treated symmetrically. They also show that the output settles from a change of din alone, with no clock edge between the change and the sample.

// File: rtl/bitstack_pkg.sv
package bitstack_pkg;

  localparam int GRP_W   = 3;
  localparam int N_GRP   = 2;
  localparam int IN_W    = GRP_W * N_GRP;
  localparam int CNT_W   = $clog2(IN_W + 1);

  typedef logic [GRP_W-1:0] stack3_t;

  // Sort three bits into a thermometer code: ones packed at bit 0.
  function automatic stack3_t stack3(input logic a, input logic b, input logic c);
    stack3_t s;
    s[0] = a | b | c;
    s[1] = (a & b) | (a & c) | (b & c);
    s[2] = a & b & c;
    return s;
  endfunction

  // Even-parity flag of a group, read from its stack (0 or 2 ones).
  function automatic logic stack_even(input stack3_t s);
    return ~s[0] | (s[1] & ~s[2]);
  endfunction

  // True when a 3-bit vector is thermometer shaped.
  function automatic logic is_thermo(input stack3_t s);
    return (~s[1] | s[0]) & (~s[2] | s[1]);
  endfunction

endpackage

// File: rtl/bitstack_stacker3.sv
module bitstack_stacker3
  import bitstack_pkg::*;
(
  input  logic [GRP_W-1:0] bits_in,
  output stack3_t          stk_out
);

  assign stk_out = stack3(bits_in[0], bits_in[1], bits_in[2]);

endmodule

// File: rtl/bitstack_merge.sv
module bitstack_merge
  import bitstack_pkg::*;
(
  input  stack3_t lo_stk,
  input  stack3_t hi_stk,
  output stack3_t ovf_stk
);

  // Pair each lower-stack bit with the mirrored upper-stack bit; the AND
  // of a pair is set only when the two stacks together pass three ones.
  stack3_t ovf_raw;

  for (genvar g = 0; g < GRP_W; g++) begin : g_pair
    assign ovf_raw[g] = lo_stk[g] & hi_stk[GRP_W-1-g];
  end

  bitstack_stacker3 u_restack (
    .bits_in (ovf_raw),
    .stk_out (ovf_stk)
  );

endmodule

// File: rtl/bitstack_encode.sv
module bitstack_encode
  import bitstack_pkg::*;
(
  input  stack3_t           lo_stk,
  input  stack3_t           hi_stk,
  input  stack3_t           ovf_stk,
  output logic [CNT_W-1:0]  cnt
);

  logic lo_even, hi_even;
  logic at_least_two, at_most_three, all_six;
  logic any_ovf;

  assign lo_even = stack_even(lo_stk);
  assign hi_even = stack_even(hi_stk);

  assign any_ovf       = ovf_stk[0] | ovf_stk[1] | ovf_stk[2];
  assign at_least_two  = lo_stk[1] | hi_stk[1] | (lo_stk[0] & hi_stk[0]);
  assign at_most_three = ~any_ovf;
  assign all_six       = lo_stk[2] & hi_stk[2];

  assign cnt[0] = lo_even ^ hi_even;
  assign cnt[1] = (at_least_two & at_most_three) | all_six;
  assign cnt[2] = any_ovf;

endmodule

// File: rtl/bitstack_counter63.sv
module bitstack_counter63
  import bitstack_pkg::*;
(
  input  logic [5:0] din,
  output logic [2:0] cnt
);

  stack3_t grp_stk [N_GRP];
  stack3_t h_stk, i_stk, k_stk;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    bitstack_stacker3 u_stack (
      .bits_in (din[g*GRP_W +: GRP_W]),
      .stk_out (grp_stk[g])
    );
  end

  assign h_stk = grp_stk[0];
  assign i_stk = grp_stk[1];

  bitstack_merge u_merge (
    .lo_stk  (h_stk),
    .hi_stk  (i_stk),
    .ovf_stk (k_stk)
  );

  bitstack_encode u_encode (
    .lo_stk  (h_stk),
    .hi_stk  (i_stk),
    .ovf_stk (k_stk),
    .cnt     (cnt)
  );

endmodule

// File: rtl/bitstack_counter63_chk.sv
module bitstack_counter63_chk
  import bitstack_pkg::*;
(
  input logic [5:0] din,
  input logic [2:0] cnt,
  input stack3_t    h_stk,
  input stack3_t    i_stk,
  input stack3_t    k_stk
);

  int n_ones;
  assign n_ones = $countones(din);

  always_comb begin
    // R1
    lo_stack_chk: assert (is_thermo(h_stk) && $countones(h_stk) == $countones(din[2:0]))
      else $error("lower group stack malformed");
    // R1
    hi_stack_chk: assert (is_thermo(i_stk) && $countones(i_stk) == $countones(din[5:3]))
      else $error("upper group stack malformed");
    // R3
    ovf_stack_chk: assert (is_thermo(k_stk) &&
                           $countones(k_stk) == ((n_ones > 3) ? n_ones - 3 : 0))
      else $error("overflow stack malformed");
    // R4
    lsb_parity_chk: assert (cnt[0] == n_ones[0])
      else $error("weight-1 bit wrong");
    // R5
    four_up_chk: assert (cnt[2] == (n_ones >= 4))
      else $error("weight-4 bit wrong");
    // R6
    mid_bit_chk: assert (cnt[1] == (n_ones == 2 || n_ones == 3 || n_ones == 6))
      else $error("weight-2 bit wrong");
  end

endmodule

bind bitstack_counter63 bitstack_counter63_chk u_chk (
  .din   (din),
  .cnt   (cnt),
  .h_stk (h_stk),
  .i_stk (i_stk),
  .k_stk (k_stk)
);

// File: tb/bitstack_counter63_test.sv
module bitstack_counter63_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] din = '0;
  logic [2:0] cnt;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;
  int         cycles = 0;

  always #2.5 clk = ~clk;

  bitstack_counter63 uut (.din(din), .cnt(cnt));

  // {din, expected count}
  localparam logic [8:0] CORNER [8] = '{
    {6'b000000, 3'd0}, {6'b111111, 3'd6}, {6'b000111, 3'd3}, {6'b111000, 3'd3},
    {6'b000011, 3'd2}, {6'b100001, 3'd2}, {6'b011110, 3'd4}, {6'b101111, 3'd5}
  };

  function automatic int pop6(input logic [5:0] v);
    int n = 0;
    for (int b = 0; b < 6; b++) if (v[b]) n++;
    return n;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s din=%b actual=%0d expected=%0d", req, din, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] v);
    @(posedge clk);
    din = v;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: idle state after reset with all inputs low
    check("R7 reset", cnt, 3'd0);

    // Corner table
    for (int t = 0; t < 8; t++) begin
      apply(CORNER[t][8:3]);
      check("R7 corner", cnt, CORNER[t][2:0]);
    end

    // R7, R4, R5, R6: exhaustive sweep against a counted reference
    for (int v = 0; v < 64; v++) begin
      int n;
      apply(6'(v));
      n = pop6(6'(v));
      check("R7 sweep", cnt, 3'(n));
      check("R4 parity", {2'b00, cnt[0]}, {2'b00, 1'(n % 2)});
      check("R5 four-or-more", {2'b00, cnt[2]}, {2'b00, 1'(n >= 4)});
      check("R6 two-three-six", {2'b00, cnt[1]}, {2'b00, 1'(n == 2 || n == 3 || n == 6)});
    end

    // R1: each group alone, its count equals the ones in that group
    for (int v = 0; v < 8; v++) begin
      apply({3'b000, 3'(v)});
      check("R1 lower group", cnt, 3'(pop6({3'b000, 3'(v)})));
      apply({3'(v), 3'b000});
      check("R1 upper group", cnt, 3'(pop6({3'(v), 3'b000})));
    end

    // R2: swapping the groups leaves the count unchanged
    for (int v = 0; v < 64; v++) begin
      logic [2:0] first;
      apply(6'(v));
      first = cnt;
      apply({din[2:0], din[5:3]});
      check("R2 group swap", cnt, first);
    end

    // R3: counts above three, carried only through the overflow stack
    apply(6'b110011); check("R3 four", cnt, 3'd4);
    apply(6'b011111); check("R3 five", cnt, 3'd5);
    apply(6'b100111); check("R3 lo3+hi1", cnt, 3'd4);
    apply(6'b111001); check("R3 lo1+hi3", cnt, 3'd4);

    // R8: output follows input with no clock edge in between
    @(negedge clk);
    din = 6'b010101;
    #1;
    check("R8 comb 3", cnt, 3'd3);
    din = 6'b111110;
    #1;
    check("R8 comb 5", cnt, 3'd5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule